// File: doc/BRIEF.md
# Refresh Request Timer

This block produces periodic refresh requests for dynamic memory in a small embedded controller. Software programs a 9-bit period into a divisor register and then sets an enable bit. From then on a down-counter running on the system clock raises a one-cycle request pulse once per programmed period. A 9-bit row pointer is kept alongside the counter. It advances on every request, so the refresh engine downstream knows which row to refresh next.

Both registers sit on a simple synchronous register bus: an 8-bit offset, a write strobe, 16-bit write data and combinational read data. A one-cycle write strobe stands in for the processor's write phase. Period values under 18 are not supported operating points.

Top module: `refresh_timer`

## Requirements
- R1: Offset 0xE2 is the period register. A write stores write-data bits 8:0. A read returns the stored value in bits 8:0, and bits 15:9 always read 0.
- R2: Offset 0xE4 is the run register. A read returns the enable bit in bit 15, zeros in bits 14:9 and the live count in bits 8:0. Writes to bits 14:0 of this register have no effect on the count. Any other offset reads as 0.
- R3: After reset the enable bit is 0, the count is 0, the period register is 0, the row pointer is 0 and the request output is low.
- R4: A write to offset 0xE4 with bit 15 set loads the count from the period register on that same clock edge and sets enable.
- R5: While enabled, the count drops by one on every clock edge that is neither a reload nor a run-register write.
- R6: On the edge after a cycle in which the enabled count equals 1, the request output goes high for exactly one cycle and the count reloads from the period register. Requests are therefore spaced exactly one period apart.
- R7: The row pointer increments by one with each request and wraps from 511 to 0.
- R8: A write to offset 0xE4 with bit 15 clear empties the count to 0 and stops all requests. The row pointer keeps its value.
- R9: A period write while enabled does not disturb the running count and takes effect at the next reload. A period write on the same edge as a reload leaves that reload using the old value.
- R10: A run-register write in a cycle where the count equals 1 takes precedence: no request is issued and the row pointer does not move.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| regAddr | input | 8 | Register offset |
| regWe | input | 1 | One-cycle write strobe |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Combinational read data |
| refReq | output | 1 | One-cycle refresh request pulse |
| refAddr | output | 9 | Refresh row pointer |

## Verification
Two events can land on the same clock edge: a terminal count reload, and a register write. The bench waits in its reference model until the count reads 1. It then issues either a period rewrite or a run-register write in exactly that cycle. For a period rewrite, it checks that the reload still takes the old period and that the new one governs the following interval. For a run-register write, it checks that the write wins: no pulse appears and the row pointer holds.

// File: rtl/refresh_timer_pkg.sv
package refresh_timer_pkg;
  typedef struct packed {
    logic wrDiv;     // store a new period
    logic loadCnt;   // reload count from period (enable write)
    logic clearCnt;  // empty the count (disable write)
    logic decCnt;    // count down by one
    logic fire;      // terminal count: reload, pulse, advance row
  } rfshStrobe_t;
endpackage

// File: rtl/refresh_timer_ctrl.sv
module refresh_timer_ctrl
  import refresh_timer_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] DIV_OFS  = 8'hE2,
  parameter logic [ADDR_W-1:0] RUN_OFS  = 8'hE4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic              enBit,
  input  logic              cntAtOne,
  output rfshStrobe_t       strobe,
  output logic              enableQ
);
  logic wrRun;
  assign wrRun = regWe && (regAddr == RUN_OFS);

  always_ff @(posedge clk) begin
    if (rst)        enableQ <= 1'b0;
    else if (wrRun) enableQ <= enBit;
  end

  always_comb begin
    strobe          = '0;
    strobe.wrDiv    = regWe && (regAddr == DIV_OFS);
    strobe.loadCnt  = wrRun && enBit;
    strobe.clearCnt = wrRun && !enBit;
    strobe.fire     = enableQ && !wrRun && cntAtOne;
    strobe.decCnt   = enableQ && !wrRun && !cntAtOne;
  end

  // R4
  en_set_chk: assert property (@(posedge clk) disable iff (rst)
    (regWe && regAddr == RUN_OFS && enBit) |=> enableQ);
  // R8
  en_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (regWe && regAddr == RUN_OFS && !enBit) |=> !enableQ);
endmodule

// File: rtl/refresh_timer_dp.sv
module refresh_timer_dp
  import refresh_timer_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  rfshStrobe_t      strobe,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] divQ,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] refAddr,
  output logic             refReq,
  output logic             cntAtOne
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign cntAtOne = (count == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      divQ    <= '0;
      count   <= '0;
      refAddr <= '0;
      refReq  <= 1'b0;
    end else begin
      if (strobe.wrDiv) divQ <= wrData;
      if (strobe.clearCnt)                    count <= '0;
      else if (strobe.loadCnt || strobe.fire) count <= divQ;
      else if (strobe.decCnt)                 count <= count - ONE;
      if (strobe.fire) refAddr <= refAddr + ONE;
      refReq <= strobe.fire;
    end
  end

  // R6
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    refReq |-> (count == $past(divQ)));
  // R6
  pulse_once_chk: assert property (@(posedge clk) disable iff (rst)
    (refReq && divQ > ONE) |=> !refReq);
  // R7
  row_step_chk: assert property (@(posedge clk) disable iff (rst)
    refReq |-> (refAddr == CNT_W'($past(refAddr) + ONE)));
  // R8
  clear_keep_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.clearCnt |=> (count == '0 && refAddr == $past(refAddr) && !refReq));
endmodule

// File: rtl/refresh_timer.sv
module refresh_timer
  import refresh_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 9,
  parameter logic [ADDR_W-1:0] DIV_OFS = 8'hE2,
  parameter logic [ADDR_W-1:0] RUN_OFS = 8'hE4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              refReq,
  output logic [CNT_W-1:0]  refAddr
);
  localparam int PAD_DIV = DATA_W - CNT_W;
  localparam int PAD_RUN = DATA_W - 1 - CNT_W;

  rfshStrobe_t      strobe;
  logic             enableQ, cntAtOne;
  logic [CNT_W-1:0] divQ, count;

  refresh_timer_ctrl #(.ADDR_W(ADDR_W), .DIV_OFS(DIV_OFS), .RUN_OFS(RUN_OFS)) u_ctrl (
    .clk(clk), .rst(rst), .regAddr(regAddr), .regWe(regWe),
    .enBit(regWdata[DATA_W-1]), .cntAtOne(cntAtOne),
    .strobe(strobe), .enableQ(enableQ)
  );

  refresh_timer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .wrData(regWdata[CNT_W-1:0]),
    .divQ(divQ), .count(count), .refAddr(refAddr), .refReq(refReq),
    .cntAtOne(cntAtOne)
  );

  always_comb begin
    if (regAddr == DIV_OFS)      regRdata = {{PAD_DIV{1'b0}}, divQ};
    else if (regAddr == RUN_OFS) regRdata = {enableQ, {PAD_RUN{1'b0}}, count};
    else                         regRdata = '0;
  end

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !enableQ |-> (count == '0 && !strobe.fire));
endmodule

// File: tb/refresh_timer_bench.sv
module refresh_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  regAddr = 8'h00;
  logic        regWe = 1'b0;
  logic [15:0] regWdata = 16'h0000;
  logic [15:0] regRdata;
  logic        refReq;
  logic [8:0]  refAddr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // behavioural reference state
  int mEn = 0, mCnt = 0, mDiv = 0, mAddr = 0, mReq = 0;

  refresh_timer u_refresh_timer (
    .clk(clk), .rst(rst), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .refReq(refReq), .refAddr(refAddr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic int modelRead(input logic [7:0] a);
    if (a == 8'hE2) return mDiv;
    if (a == 8'hE4) return (mEn << 15) | mCnt;
    return 0;
  endfunction

  // reference model update
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      mEn = 0; mCnt = 0; mDiv = 0; mAddr = 0; mReq = 0;
    end else begin
      automatic bit wrD  = regWe && regAddr == 8'hE2;
      automatic bit wrR  = regWe && regAddr == 8'hE4;
      automatic bit fire = (mEn != 0) && !wrR && mCnt == 1;
      automatic int nCnt = mCnt;
      if (wrR)             nCnt = regWdata[15] ? mDiv : 0;
      else if (fire)       nCnt = mDiv;
      else if (mEn != 0)   nCnt = mCnt - 1;
      mCnt = nCnt;
      mReq = fire;
      if (fire) mAddr = (mAddr + 1) % 512;
      if (wrR)  mEn = regWdata[15];
      if (wrD)  mDiv = regWdata & 16'h01FF;
    end
    if (cyc > WATCHDOG) begin
      check(1'b0, "watchdog", cyc, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (!rst) begin
      check(refReq == mReq[0], "R6 refReq", refReq, mReq);
      check(refAddr == mAddr[8:0], "R7 refAddr", refAddr, mAddr);
      check(regRdata == modelRead(regAddr), "R2 regRdata", regRdata, modelRead(regAddr));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    #1; regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    #1; regWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    regAddr = a; #1; d = regRdata;
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [15:0] v;
    int t0, t1, startAddr, pulses;
    waitCyc(3);
    rst = 1'b0;
    @(negedge clk);
    // R3 reset state
    check(refReq == 1'b0 && refAddr == 9'd0, "R3 outputs", {refReq, refAddr}, 0);
    rd(8'hE4, v); check(v == 16'h0000, "R3 run reg", v, 0);
    rd(8'hE2, v); check(v == 16'h0000, "R3 period reg", v, 0);

    // R1 upper bits dropped
    wr(8'hE2, 16'hFFFF);
    rd(8'hE2, v); check(v == 16'h01FF, "R1 period mask", v, 16'h01FF);
    // R2 count bits not writable, unused offset reads 0
    wr(8'hE4, 16'h7FFF);
    rd(8'hE4, v); check(v == 16'h0000, "R2 count ignores write", v, 0);
    rd(8'h10, v); check(v == 16'h0000, "R2 other offset", v, 0);

    // R4 enable loads period
    wr(8'hE2, 16'd20);
    wr(8'hE4, 16'h8000);
    rd(8'hE4, v); check(v == 16'h8014, "R4 load on enable", v, 16'h8014);
    // R5 decrement
    waitCyc(3);
    rd(8'hE4, v); check(v == 16'h8011, "R5 decrement", v, 16'h8011);
    // R6 spacing
    while (refReq !== 1'b1) @(negedge clk);
    t0 = cyc;
    @(negedge clk);
    while (refReq !== 1'b1) @(negedge clk);
    t1 = cyc;
    check(t1 - t0 == 20, "R6 spacing", t1 - t0, 20);

    // R9 rewrite mid-period: takes effect next reload
    waitCyc(4);
    wr(8'hE2, 16'd25);
    rd(8'hE4, v); check(v[8:0] != 9'd25, "R9 running count kept", v[8:0], 0);
    while (refReq !== 1'b1) @(negedge clk);
    rd(8'hE4, v); check(v[8:0] == 9'd25, "R9 new period at reload", v[8:0], 25);

    // R9 collision: period write on reload edge uses old value
    while (mCnt != 1) @(negedge clk);
    wr(8'hE2, 16'd30);
    rd(8'hE4, v); check(v[8:0] == 9'd25 && refReq, "R9 collision reload old", v[8:0], 25);
    t0 = cyc;
    @(negedge clk);
    while (refReq !== 1'b1) @(negedge clk);
    check(cyc - t0 == 25, "R9 interval old period", cyc - t0, 25);
    @(negedge clk);
    while (refReq !== 1'b1) @(negedge clk);
    rd(8'hE4, v); check(v[8:0] == 9'd30, "R9 new period follows", v[8:0], 30);

    // R10 run write at terminal count wins
    while (mCnt != 1) @(negedge clk);
    startAddr = refAddr;
    wr(8'hE4, 16'h8000);
    check(refReq == 1'b0, "R10 no pulse", refReq, 0);
    check(refAddr == startAddr[8:0], "R10 row held", refAddr, startAddr);

    // R8 disable keeps row pointer
    waitCyc(7);
    startAddr = refAddr;
    wr(8'hE4, 16'h0000);
    pulses = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (refReq) pulses++;
    end
    check(pulses == 0, "R8 no requests", pulses, 0);
    rd(8'hE4, v); check(v == 16'h0000, "R8 count cleared", v, 0);
    check(refAddr == startAddr[8:0], "R8 row kept", refAddr, startAddr);

    // R7 wrap: 512 requests return pointer to start
    wr(8'hE2, 16'd18);
    startAddr = refAddr;
    wr(8'hE4, 16'h8000);
    pulses = 0;
    while (pulses < 512) begin
      @(negedge clk);
      if (refReq) pulses++;
    end
    check(refAddr == startAddr[8:0], "R7 wrap", refAddr, startAddr);
    wr(8'hE4, 16'h0000);
    waitCyc(3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule